// File: doc/BRIEF.md
# Fixed-Point Filtered-Reference LMS Noise Canceller

This block cancels noise one sample at a time. Each accepted reference sample is pushed into a 32-deep history. The block then forms an anti-noise output from an adaptive 32-tap FIR. Next it passes the reference through a fixed 8-tap FIR, the model of the speaker-to-error-microphone path, to get a filtered reference. Last it adapts every adaptive coefficient from the filtered-reference history and the error sample that came with the reference.

The step size is a programmable Q15 value. It is divided by the running power of the filtered reference plus a programmable floor. A loud reference therefore adapts slowly and a quiet one adapts fast. All arithmetic is Q15. A single multiplier with a wide accumulator serves every phase, and a bit-serial restoring divider forms the normalized step. A host loads the path-model coefficients, the step size and the floor while the block is idle. Samples enter through a ready/valid handshake, and a one-cycle strobe marks each finished result.

Top module: `fxlms_canceller`

## Requirements
- R1: After reset, y_out and xf_out are 0, busy is 0, in_ready is 1, y_valid is 0, all adaptive coefficients are 0, the reference histories are 0, the step size is 0 and the power floor is 64.
- R2: y_out = sat16((Σ_{k=0..31} psat(w[k]·x[n−k])) >>> 15). x[n] is the sample just accepted, at k=0. The w[k] are the coefficients before this sample's update. psat clamps to [−2^30, 2^30−1] and sat16 clamps to [−32768, 32767].
- R3: xf_out = sat16((Σ_{j=0..7} psat(s[j]·x[n−j])) >>> 15). Path coefficient s[j] is written with s_we=1, s_addr=j and s_data, and is never adapted.
- R4: Every product is clamped to [−2^30, 2^30−1] before the shift by 15. A full-scale negative times a full-scale negative gives 32767.
- R5: The power P is the sum of sq(xf) over the newest 32 filtered samples, including the current one, where sq(v) = (v·v) >> 15. The divisor is P + floor and is never zero.
- R6: m = psat(mu·e) >>> 15. The step magnitude is min(floor_div(|m|·2^15, P + floor), 32767), and the step takes the sign of m. Then w[k] ← sat16(w[k] + (psat(step·xf[n−k]) >>> 15)) for every k.
- R7: The floor register resets to 64. Writing 0 to it stores 1.
- R8: Writes of s, mu and floor are ignored while busy is 1.
- R9: A sample is taken when in_valid and in_ready are both 1, and in_ready = !busy. y_valid pulses for one cycle as busy falls, within 256 clocks of acceptance. in_valid while busy has no effect.
- R10: y_out saturates to the Q15 range when the adapted filter sum exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New reference/error pair offered |
| in_ready | output | 1 | Block idle, pair may be taken |
| x_in | input | 16 | Reference sample, Q15 |
| e_in | input | 16 | Error-microphone sample, Q15 |
| y_valid | output | 1 | One-cycle strobe: results ready |
| y_out | output | 16 | Anti-noise sample, Q15 |
| xf_out | output | 16 | Filtered reference of the last sample, Q15 |
| busy | output | 1 | Processing a sample |
| s_we | input | 1 | Path-model coefficient write |
| s_addr | input | 3 | Path-model tap index |
| s_data | input | 16 | Path-model coefficient, Q15 |
| mu_we | input | 1 | Step-size write |
| mu_data | input | 16 | Step size, Q15 signed |
| eps_we | input | 1 | Power-floor write |
| eps_data | input | 16 | Power floor, unsigned Q15 |

## Verification
Assertions check several things on every cycle. The divisor handed to the divider is nonzero. Every quotient and remainder satisfy the division identity. The power sum never exceeds its window bound, and the floor register is never zero. Configuration registers stay stable while busy, a busy period ends within 256 clocks, and the result strobe follows busy. Only the bench scenarios can show the numeric results. Those are the output and filtered-reference values, the saturation at both range ends, and the effect of normalization on adaptation across many samples. The bench also shows that writes and offers made while busy leave later outputs unchanged.

// File: rtl/fxlms_pkg.sv
package fxlms_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_FIRW, PH_YOUT, PH_FIRS, PH_XF, PH_MUE, PH_DIVGO, PH_DIVW, PH_UPD
  } phase_t;

  // clamp a wide signed value to Q15
  function automatic logic signed [15:0] sat_q15(input logic signed [63:0] v);
    if (v > 64'sd32767) return 16'sd32767;
    if (v < -64'sd32768) return -16'sd32768;
    return 16'(v);
  endfunction

  // clamp a Q15*Q15 product to the 31-bit signed range
  function automatic logic signed [31:0] sat_prod(input logic signed [31:0] p);
    if (p > 32'sd1073741823) return 32'sd1073741823;
    if (p < -32'sd1073741824) return -32'sd1073741824;
    return p;
  endfunction

  // Q15 square, non-negative
  function automatic logic [16:0] sq_q15(input logic signed [15:0] v);
    logic signed [31:0] p;
    p = v * v;
    return 17'(p >>> 15);
  endfunction

endpackage

// File: rtl/fxlms_mac.sv
module fxlms_mac #(
  parameter int DW   = 16,
  parameter int ACCW = 37
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   clr,
  input  logic signed [DW-1:0]   a,
  input  logic signed [DW-1:0]   b,
  output logic signed [2*DW-1:0] prod,
  output logic signed [ACCW-1:0] acc
);
  import fxlms_pkg::*;

  logic signed [2*DW-1:0] prod_raw;
  logic signed [ACCW-1:0] base;

  assign prod_raw = a * b;
  assign prod     = sat_prod(prod_raw);
  assign base     = clr ? '0 : acc;

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= base + ACCW'(prod);
  end

endmodule

// File: rtl/fxlms_div.sv
module fxlms_div #(
  parameter int NW = 31,
  parameter int VW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CW = $clog2(NW + 1);

  logic [VW-1:0] rem_q, dvs_q;
  logic [NW-1:0] quo_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [VW:0]   trial;
  logic          ge;

  assign trial    = {rem_q, quo_q[NW-1]};
  assign ge       = trial >= {1'b0, dvs_q};
  assign quotient = quo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0; dvs_q <= '0; quo_q <= '0; dvd_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvd_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CW'(NW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? VW'(trial - {1'b0, dvs_q}) : VW'(trial);
        quo_q <= {quo_q[NW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  // R5
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> divisor != '0);

  // R6
  div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (64'(quo_q) * 64'(dvs_q) + 64'(rem_q) == 64'(dvd_q)) && (rem_q < dvs_q));

endmodule

// File: rtl/fxlms_canceller.sv
module fxlms_canceller #(
  parameter  int TAPS  = 32,
  parameter  int STAPS = 8,
  localparam int SAW   = $clog2(STAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic signed [15:0] x_in,
  input  logic signed [15:0] e_in,
  output logic              y_valid,
  output logic signed [15:0] y_out,
  output logic signed [15:0] xf_out,
  output logic              busy,
  input  logic              s_we,
  input  logic [SAW-1:0]    s_addr,
  input  logic signed [15:0] s_data,
  input  logic              mu_we,
  input  logic signed [15:0] mu_data,
  input  logic              eps_we,
  input  logic [15:0]       eps_data
);
  import fxlms_pkg::*;

  localparam int DW   = 16;
  localparam int IW   = $clog2(TAPS);
  localparam int PW   = $clog2(TAPS) + DW;
  localparam int NW   = 2 * DW - 1;
  localparam int ACCW = 2 * DW + $clog2(TAPS);
  localparam logic [15:0] EPS_RST = 16'd64;

  phase_t ph_q;
  logic [IW-1:0] idx_q;
  logic signed [15:0] w_q  [TAPS];
  logic signed [15:0] x_q  [TAPS];
  logic signed [15:0] xf_q [TAPS];
  logic [STAPS-1:0][15:0] s_q;
  logic signed [15:0] mu_q, e_q, me_q, step_q, y_q, xfo_q;
  logic [15:0] eps_q;
  logic [PW-1:0] pwr_q;
  logic busy_q, yv_q;
  logic [8:0] lat_q;

  // named internal events
  logic accept_ev, cfg_open, div_start, div_done;
  logic signed [15:0] mac_a, mac_b;
  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] acc;
  logic mac_en;
  logic signed [15:0] xf_new;
  logic signed [16:0] me_ext;
  logic [16:0] me_mag;
  logic [NW-1:0] div_q;
  logic [NW-1:0] dividend;
  logic [PW-1:0] divisor;
  logic [14:0] step_mag;

  assign accept_ev = in_valid && !busy_q && (ph_q == PH_IDLE);
  assign cfg_open  = !busy_q;
  assign in_ready  = !busy_q;
  assign busy      = busy_q;
  assign y_valid   = yv_q;
  assign y_out     = y_q;
  assign xf_out    = xfo_q;

  // operand selection for the shared multiplier
  always_comb begin
    mac_a = '0;
    mac_b = '0;
    unique case (ph_q)
      PH_FIRW: begin mac_a = w_q[idx_q];             mac_b = x_q[idx_q];  end
      PH_FIRS: begin mac_a = $signed(s_q[idx_q[SAW-1:0]]); mac_b = x_q[idx_q]; end
      PH_MUE:  begin mac_a = mu_q;                   mac_b = e_q;         end
      PH_UPD:  begin mac_a = step_q;                 mac_b = xf_q[idx_q]; end
      default: ;
    endcase
  end
  assign mac_en = (ph_q == PH_FIRW) || (ph_q == PH_FIRS);

  fxlms_mac #(.DW(DW), .ACCW(ACCW)) mac_i (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .clr(idx_q == '0),
    .a(mac_a), .b(mac_b), .prod(prod), .acc(acc)
  );

  assign xf_new    = sat_q15(64'(acc >>> 15));
  assign me_ext    = 17'(me_q);
  assign me_mag    = me_ext[16] ? unsigned'(17'(-me_ext)) : unsigned'(me_ext);
  assign dividend  = NW'({me_mag, 15'b0});
  assign divisor   = pwr_q + PW'(eps_q);
  assign div_start = (ph_q == PH_DIVGO);
  assign step_mag  = (div_q > NW'(32767)) ? 15'h7fff : div_q[14:0];

  fxlms_div #(.NW(NW), .VW(PW)) div_i (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(dividend), .divisor(divisor), .done(div_done), .quotient(div_q)
  );

  // path-model coefficient registers, one per tap
  for (genvar j = 0; j < STAPS; j++) begin : g_scoef
    always_ff @(posedge clk) begin
      if (!rst_n) s_q[j] <= '0;
      else if (cfg_open && s_we && s_addr == SAW'(j)) s_q[j] <= s_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mu_q  <= '0;
      eps_q <= EPS_RST;
    end else if (cfg_open) begin
      if (mu_we)  mu_q  <= mu_data;
      if (eps_we) eps_q <= (eps_data == '0) ? 16'd1 : eps_data;
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; idx_q <= '0; busy_q <= 1'b0; yv_q <= 1'b0;
      e_q <= '0; me_q <= '0; step_q <= '0; y_q <= '0; xfo_q <= '0; pwr_q <= '0;
      for (int i = 0; i < TAPS; i++) begin
        w_q[i] <= '0; x_q[i] <= '0; xf_q[i] <= '0;
      end
    end else begin
      yv_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (accept_ev) begin
          for (int i = TAPS - 1; i > 0; i--) x_q[i] <= x_q[i-1];
          x_q[0] <= x_in;
          e_q    <= e_in;
          busy_q <= 1'b1;
          idx_q  <= '0;
          ph_q   <= PH_FIRW;
        end
        PH_FIRW: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IW'(TAPS - 1)) begin idx_q <= '0; ph_q <= PH_YOUT; end
        end
        PH_YOUT: begin
          y_q  <= sat_q15(64'(acc >>> 15));
          ph_q <= PH_FIRS;
        end
        PH_FIRS: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IW'(STAPS - 1)) begin idx_q <= '0; ph_q <= PH_XF; end
        end
        PH_XF: begin
          for (int i = TAPS - 1; i > 0; i--) xf_q[i] <= xf_q[i-1];
          xf_q[0] <= xf_new;
          xfo_q   <= xf_new;
          pwr_q   <= pwr_q + PW'(sq_q15(xf_new)) - PW'(sq_q15(xf_q[TAPS-1]));
          ph_q    <= PH_MUE;
        end
        PH_MUE: begin
          me_q <= 16'(prod >>> 15);
          ph_q <= PH_DIVGO;
        end
        PH_DIVGO: ph_q <= PH_DIVW;
        PH_DIVW: if (div_done) begin
          step_q <= me_q[15] ? -$signed({1'b0, step_mag}) : $signed({1'b0, step_mag});
          idx_q  <= '0;
          ph_q   <= PH_UPD;
        end
        PH_UPD: begin
          w_q[idx_q] <= sat_q15(64'(w_q[idx_q]) + 64'(prod >>> 15));
          idx_q <= idx_q + 1'b1;
          if (idx_q == IW'(TAPS - 1)) begin
            idx_q  <= '0;
            ph_q   <= PH_IDLE;
            busy_q <= 1'b0;
            yv_q   <= 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // latency observer for the bound check
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_q) lat_q <= '0;
    else                   lat_q <= lat_q + 1'b1;
  end

  // R9
  latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q < 9'd256);

  // R9
  strobe_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> !busy && $past(busy));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(s_q) && $stable(mu_q) && $stable(eps_q));

  // R7
  floor_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eps_q != '0);

  // R5
  power_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q <= PW'(TAPS * 32768));

endmodule

// File: tb/fxlms_canceller_tb.sv
`timescale 1ns/1ps
module fxlms_canceller_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, y_valid, busy;
  logic signed [15:0] x_in, e_in, y_out, xf_out, s_data, mu_data;
  logic [2:0] s_addr;
  logic s_we, mu_we, eps_we;
  logic [15:0] eps_data;

  always #4 clk = ~clk;

  fxlms_canceller dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_in(x_in), .e_in(e_in), .y_valid(y_valid), .y_out(y_out), .xf_out(xf_out),
    .busy(busy), .s_we(s_we), .s_addr(s_addr), .s_data(s_data),
    .mu_we(mu_we), .mu_data(mu_data), .eps_we(eps_we), .eps_data(eps_data)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;
  bit meddle = 0;

  // bench-side model state
  int mw[32], mx[32], mxf[32], ms[8];
  int mmu = 0, meps = 64;
  longint mp = 0;

  function automatic int bsat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic longint bpsat(longint p);
    if (p > 64'sd1073741823) return 64'sd1073741823;
    if (p < -64'sd1073741824) return -64'sd1073741824;
    return p;
  endfunction

  function automatic longint bsq(int v);
    return (longint'(v) * longint'(v)) >> 15;
  endfunction

  task automatic model_step(input int x, input int e, output int ey, output int exf);
    longint acc, d, mag, q;
    int m, step, oldest;
    for (int i = 31; i > 0; i--) mx[i] = mx[i-1];
    mx[0] = x;
    acc = 0;
    for (int k = 0; k < 32; k++) acc += bpsat(longint'(mw[k]) * mx[k]);
    ey = bsat(acc >>> 15);
    acc = 0;
    for (int j = 0; j < 8; j++) acc += bpsat(longint'(ms[j]) * mx[j]);
    exf = bsat(acc >>> 15);
    oldest = mxf[31];
    for (int i = 31; i > 0; i--) mxf[i] = mxf[i-1];
    mxf[0] = exf;
    mp = mp + bsq(exf) - bsq(oldest);
    m = int'(bpsat(longint'(mmu) * e) >>> 15);
    d = mp + meps;
    mag = (m < 0) ? -longint'(m) : longint'(m);
    q = (mag << 15) / d;
    if (q > 32767) q = 32767;
    step = (m < 0) ? -int'(q) : int'(q);
    for (int k = 0; k < 32; k++)
      mw[k] = bsat(longint'(mw[k]) + (bpsat(longint'(step) * mxf[k]) >>> 15));
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_s(input int a, input int v);
    @(negedge clk); s_we = 1; s_addr = 3'(a); s_data = 16'(v);
    @(negedge clk); s_we = 0;
    ms[a] = v;
  endtask

  task automatic cfg_mu(input int v);
    @(negedge clk); mu_we = 1; mu_data = 16'(v);
    @(negedge clk); mu_we = 0;
    mmu = v;
  endtask

  task automatic cfg_eps(input int v);
    @(negedge clk); eps_we = 1; eps_data = 16'(v);
    @(negedge clk); eps_we = 0;
    meps = (v == 0) ? 1 : v;
  endtask

  task automatic do_sample(input int x, input int e, input string tag);
    int ey, exf, cyc;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; x_in = 16'(x); e_in = 16'(e);
    @(negedge clk);
    in_valid = 0;
    model_step(x, e, ey, exf);
    cyc = 1;
    while (!y_valid && cyc < 1000) begin
      if (meddle && cyc == 5) begin
        in_valid = 1; x_in = 16'sd12345; e_in = 16'sd20000;
        s_we = 1; s_addr = 3'd0; s_data = 16'sd777;
        mu_we = 1; mu_data = 16'sd0;
        eps_we = 1; eps_data = 16'd5;
      end else if (meddle && cyc == 6) begin
        in_valid = 0; s_we = 0; mu_we = 0; eps_we = 0;
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 256, "R9 latency", cyc, 255);
    chk(int'(y_out) == ey, {tag, " y_out"}, int'(y_out), ey);
    chk(int'(xf_out) == exf, {tag, " xf_out"}, int'(xf_out), exf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    for (int i = 0; i < 32; i++) begin mw[i] = 0; mx[i] = 0; mxf[i] = 0; end
    for (int j = 0; j < 8; j++) ms[j] = 0;
    rst_n = 0; in_valid = 0; x_in = 0; e_in = 0;
    s_we = 0; s_addr = 0; s_data = 0; mu_we = 0; mu_data = 0; eps_we = 0; eps_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(y_out == 0, "R1 y_out reset", int'(y_out), 0);
    chk(xf_out == 0, "R1 xf_out reset", int'(xf_out), 0);
    chk(busy == 0, "R1 busy reset", int'(busy), 0);
    chk(in_ready == 1, "R1 in_ready reset", int'(in_ready), 1);
    chk(y_valid == 0, "R1 y_valid reset", int'(y_valid), 0);

    // R1: zero coefficients, zero step → zero output and no adaptation
    do_sample(9000, 9000, "R1 first sample");

    // R3 path model load, R7 default floor in effect
    cfg_s(0, 16384); cfg_s(1, -8192); cfg_s(2, 4096); cfg_s(4, 2048); cfg_s(7, -1024);
    cfg_mu(8192);
    do_sample(10000, 3000, "R3 R7 directed");

    // R2 R3 R5 R6 random moderate amplitudes
    for (int n = 0; n < 60; n++)
      do_sample(int'($urandom_range(16000)) - 8000, int'($urandom_range(16000)) - 8000, "R2 R6 random");

    // R5 R6: quiet then loud reference changes the normalized step
    for (int n = 0; n < 10; n++)
      do_sample(int'($urandom_range(200)) - 100, 12000, "R5 quiet");
    for (int n = 0; n < 10; n++)
      do_sample(int'($urandom_range(60000)) - 30000, 12000, "R5 loud");

    // R8 R9: config writes and offers while busy are ignored
    meddle = 1;
    for (int n = 0; n < 4; n++)
      do_sample(int'($urandom_range(16000)) - 8000, int'($urandom_range(16000)) - 8000, "R8 R9 busy writes");
    meddle = 0;
    do_sample(5000, -5000, "R8 after busy writes");

    // R7: floor of zero stored as one
    cfg_eps(0);
    for (int n = 0; n < 5; n++)
      do_sample(int'($urandom_range(2000)) - 1000, 500, "R7 floor zero");

    // R10: large step, full-scale signals push the output to the limits
    cfg_mu(32767); cfg_eps(1);
    for (int n = 0; n < 40; n++)
      do_sample(int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768, "R10 saturation");

    // R4: full-scale negative times full-scale negative
    cfg_mu(0);
    cfg_s(0, -32768);
    for (int j = 1; j < 8; j++) cfg_s(j, 0);
    do_sample(-32768, 0, "R4 product clamp");
    chk(int'(xf_out) == 32767, "R4 xf clamp value", int'(xf_out), 32767);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule